// File: doc/BRIEF.md
# Operand Barrel Shifter with Shifter Carry

This combinational block prepares the second operand of a processor datapath. A 32-bit value is shifted or rotated in one of four ways, by an amount that is either a 5-bit constant from the instruction or the low byte of a register. A shifter carry is produced alongside the result. It is the last bit moved out of the word, or the incoming carry flag when nothing moved.

A separate operand mode builds a 32-bit constant from an 8-bit literal and a 4-bit rotate field. The literal is rotated right by twice the field. The carry rule in this mode follows the same idea.

Shift type encoding used throughout: `shiftType` 2'b00 = logical left, 2'b01 = logical right, 2'b10 = arithmetic right, 2'b11 = rotate right.

Top module: `barrel_shift`

## Requirements
- R1: Logical left (00) by 1..31 fills the low bits with zero, and `carryOut` is the last bit pushed out past bit 31.
- R2: Logical right (01) by 1..31 fills the high bits with zero, and `carryOut` is the last bit pushed out below bit 0.
- R3: Arithmetic right (10) fills the high bits with copies of the original bit 31, so result bit 31 always equals operand bit 31.
- R4: Rotate right (11) by 1..31 moves the bits leaving bit 0 back in at bit 31, and `carryOut` equals result bit 31.
- R5: Rotate right with `amountFromReg`=0 and `immAmount`=0 is a one-bit rotate through carry. The result is {carryIn, operand[31:1]} and `carryOut` is operand[0].
- R6: With `amountFromReg`=0, an `immAmount` of 0 means a shift by 32 for logical right and arithmetic right. For logical left it passes the operand and `carryIn` through unchanged.
- R7: With `amountFromReg`=1, the 8-bit `regAmount` is the amount. A value of 0 passes the operand and `carryIn` through unchanged for every shift type.
- R8: A register logical left or logical right of exactly 32 gives zero, with carry equal to operand bit 0 (left) or bit 31 (right). Above 32, both the result and the carry are zero.
- R9: A register arithmetic right of 32 or more gives 32 copies of operand bit 31, with carry equal to operand bit 31.
- R10: A register rotate by a nonzero multiple of 32 leaves the operand unchanged, with carry equal to operand bit 31.
- R11: With `immMode`=1, the result is {24'b0, immConst} rotated right by 2*immRotate. The shift inputs are ignored. `carryOut` is result bit 31 when `immRotate` is nonzero, and `carryIn` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 32 | Value to shift |
| shiftType | input | 2 | Shift kind, encoded as above |
| immAmount | input | 5 | Constant shift amount |
| regAmount | input | 8 | Low byte of the register holding the amount |
| amountFromReg | input | 1 | 1 selects `regAmount`, 0 selects `immAmount` |
| carryIn | input | 1 | Current carry flag |
| immMode | input | 1 | 1 selects the rotated-literal operand |
| immConst | input | 8 | 8-bit literal for rotated-literal mode |
| immRotate | input | 4 | Rotate field; the rotation is twice this value |
| result | output | 32 | Shifted operand |
| carryOut | output | 1 | Shifter carry |

## Verification
Both `result` and `carryOut` are purely combinational, so they are due in the same cycle as the inputs that produce them, with no register in between. The bench changes the inputs on the falling clock edge. It samples the outputs one nanosecond later, long before the next rising edge, so every comparison sees settled values for exactly the stimulus just applied. The embedded checker evaluates its rules on every input change and needs no history.

// File: rtl/barrel_shift_pkg.sv
package barrel_shift_pkg;

  localparam int DATA_W  = 32;
  localparam int AMT_W   = $clog2(DATA_W) + 1;   // holds 0..DATA_W+1
  localparam int LIT_W   = 8;
  localparam int ROT_W   = 4;
  localparam int RAMT_W  = 8;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shiftKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             useLit;   // operate on the zero-extended literal
    logic             pass;     // result = source, carry = carryIn
    logic             rrx;      // one-bit rotate through carry
    shiftKind_e       kind;
    logic [AMT_W-1:0] amount;   // 0..DATA_W+1 (DATA_W+1 = "beyond")
  } shiftCtl_t;

endpackage

// File: rtl/barrel_shift_ctrl.sv
module barrel_shift_ctrl
  import barrel_shift_pkg::*;
(
  input  logic [1:0]        shiftType,
  input  logic [AMT_W-2:0]  immAmount,
  input  logic [RAMT_W-1:0] regAmount,
  input  logic              amountFromReg,
  input  logic              immMode,
  input  logic [ROT_W-1:0]  immRotate,
  output shiftCtl_t         ctl
);

  localparam logic [RAMT_W-1:0] FULL_R = RAMT_W'(DATA_W);
  localparam logic [AMT_W-1:0]  FULL_A = AMT_W'(DATA_W);
  localparam logic [AMT_W-1:0]  OVER_A = AMT_W'(DATA_W + 1);

  shiftKind_e reqKind;
  assign reqKind = shiftKind_e'(shiftType);

  always_comb begin
    ctl        = '0;
    ctl.kind   = reqKind;
    if (immMode) begin
      ctl.useLit = 1'b1;
      ctl.kind   = SK_ROR;
      if (immRotate == '0) ctl.pass = 1'b1;
      else                 ctl.amount = AMT_W'({immRotate, 1'b0});
    end else if (amountFromReg) begin
      if (regAmount == '0) begin
        ctl.pass = 1'b1;
      end else if (reqKind == SK_ROR) begin
        // multiples of 32 become rotate-by-0, which keeps value, carry = bit31
        ctl.amount = AMT_W'(regAmount[AMT_W-2:0]);
      end else if (regAmount > FULL_R) begin
        ctl.amount = OVER_A;
      end else begin
        ctl.amount = AMT_W'(regAmount);
      end
    end else begin
      if (immAmount == '0) begin
        case (reqKind)
          SK_LSL:  ctl.pass = 1'b1;
          SK_ROR:  ctl.rrx  = 1'b1;
          default: ctl.amount = FULL_A;
        endcase
      end else begin
        ctl.amount = AMT_W'(immAmount);
      end
    end
  end

endmodule

// File: rtl/barrel_shift_dp.sv
module barrel_shift_dp
  import barrel_shift_pkg::*;
(
  input  logic [DATA_W-1:0] operand,
  input  logic [LIT_W-1:0]  immConst,
  input  logic              carryIn,
  input  shiftCtl_t         ctl,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);

  localparam int RA_W = AMT_W - 1;

  logic [DATA_W-1:0]        src;
  logic [DATA_W:0]          leftWide;
  logic [DATA_W:0]          rightWide;
  logic signed [DATA_W:0]   arithWide;
  logic [DATA_W-1:0]        rotVal;
  logic [RA_W-1:0]          rotAmt;

  assign src    = ctl.useLit ? {{(DATA_W-LIT_W){1'b0}}, immConst} : operand;
  assign rotAmt = ctl.amount[RA_W-1:0];

  always_comb begin
    leftWide  = {1'b0, src} << ctl.amount;
    rightWide = {src, 1'b0} >> ctl.amount;
    arithWide = $signed({src, 1'b0}) >>> ctl.amount;
    rotVal    = (src >> rotAmt) | (src << (AMT_W'(DATA_W) - AMT_W'(rotAmt)));
  end

  always_comb begin
    result   = src;
    carryOut = carryIn;
    if (ctl.pass) begin
      result   = src;
      carryOut = carryIn;
    end else if (ctl.rrx) begin
      result   = {carryIn, src[DATA_W-1:1]};
      carryOut = src[0];
    end else begin
      case (ctl.kind)
        SK_LSL: begin
          result   = leftWide[DATA_W-1:0];
          carryOut = leftWide[DATA_W];
        end
        SK_LSR: begin
          result   = rightWide[DATA_W:1];
          carryOut = rightWide[0];
        end
        SK_ASR: begin
          result   = arithWide[DATA_W:1];
          carryOut = arithWide[0];
        end
        default: begin
          result   = rotVal;
          carryOut = rotVal[DATA_W-1];
        end
      endcase
    end
  end

endmodule

// File: rtl/barrel_shift.sv
module barrel_shift
  import barrel_shift_pkg::*;
(
  input  logic [31:0] operand,
  input  logic [1:0]  shiftType,
  input  logic [4:0]  immAmount,
  input  logic [7:0]  regAmount,
  input  logic        amountFromReg,
  input  logic        carryIn,
  input  logic        immMode,
  input  logic [7:0]  immConst,
  input  logic [3:0]  immRotate,
  output logic [31:0] result,
  output logic        carryOut
);

  shiftCtl_t ctl;

  barrel_shift_ctrl u_ctrl (
    .shiftType     (shiftType),
    .immAmount     (immAmount),
    .regAmount     (regAmount),
    .amountFromReg (amountFromReg),
    .immMode       (immMode),
    .immRotate     (immRotate),
    .ctl           (ctl)
  );

  barrel_shift_dp u_dp (
    .operand  (operand),
    .immConst (immConst),
    .carryIn  (carryIn),
    .ctl      (ctl),
    .result   (result),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/barrel_shift_chk.sv
module barrel_shift_chk (
  input logic [31:0] operand,
  input logic [1:0]  shiftType,
  input logic [4:0]  immAmount,
  input logic [7:0]  regAmount,
  input logic        amountFromReg,
  input logic        carryIn,
  input logic        immMode,
  input logic [7:0]  immConst,
  input logic [3:0]  immRotate,
  input logic [31:0] result,
  input logic        carryOut
);

  always_comb begin
    // R1
    lsl_zero_fill_chk: assert (!(!immMode && !amountFromReg && shiftType == 2'b00 &&
                                 immAmount != 5'd0) || result[0] == 1'b0)
      else $error("lsl low bit not zero");
    // R2
    lsr_zero_fill_chk: assert (!(!immMode && amountFromReg && shiftType == 2'b01 &&
                                 regAmount != 8'd0) || result[31] == 1'b0)
      else $error("lsr high bit not zero");
    // R3
    asr_sign_keep_chk: assert (!(!immMode && shiftType == 2'b10) || result[31] == operand[31])
      else $error("asr sign lost");
    // R5
    rrx_carry_chk: assert (!(!immMode && !amountFromReg && shiftType == 2'b11 &&
                             immAmount == 5'd0) ||
                           (carryOut == operand[0] && result[31] == carryIn))
      else $error("rrx mismatch");
    // R7
    reg_zero_pass_chk: assert (!(!immMode && amountFromReg && regAmount == 8'd0) ||
                               (result == operand && carryOut == carryIn))
      else $error("zero register amount not transparent");
    // R11
    lit_norot_chk: assert (!(immMode && immRotate == 4'd0) ||
                           (result == {24'b0, immConst} && carryOut == carryIn))
      else $error("unrotated literal mismatch");
  end

endmodule

bind barrel_shift barrel_shift_chk u_chk (.*);

// File: tb/barrel_shift_tb.sv
module barrel_shift_tb;

  localparam time CLK_HALF = 4ns;   // 125 MHz
  localparam int  WATCHDOG = 200000;

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] op;
    logic [1:0]  kind;
    logic [4:0]  immAmt;
    logic [7:0]  regAmt;
    logic        fromReg;
    logic        litMode;
    logic [7:0]  lit;
    logic [3:0]  rot;
    logic        cin;
    logic [31:0] expR;
    logic        expC;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  32'hEF00DE12, 2'd0, 5'd8,  8'd0,   1'b0, 1'b0, 8'h00, 4'd0, 1'b0, 32'h00DE1200, 1'b1}, // R1
    '{4'd3,  32'hEF00DE12, 2'd2, 5'd0,  8'd4,   1'b1, 1'b0, 8'h00, 4'd0, 1'b0, 32'hFEF00DE1, 1'b0}, // R3
    '{4'd4,  32'h0456123F, 2'd3, 5'd0,  8'd28,  1'b1, 1'b0, 8'h00, 4'd0, 1'b0, 32'h456123F0, 1'b0}, // R4
    '{4'd2,  32'h0456123F, 2'd1, 5'd5,  8'd0,   1'b0, 1'b0, 8'h00, 4'd0, 1'b0, 32'h0022B091, 1'b1}, // R2
    '{4'd1,  32'h72340200, 2'd0, 5'd3,  8'd0,   1'b0, 1'b0, 8'h00, 4'd0, 1'b0, 32'h91A01000, 1'b1}, // R1
    '{4'd3,  32'h72340200, 2'd2, 5'd0,  8'd4,   1'b1, 1'b0, 8'h00, 4'd0, 1'b1, 32'h07234020, 1'b0}, // R3
    '{4'd5,  32'h00000003, 2'd3, 5'd0,  8'd0,   1'b0, 1'b0, 8'h00, 4'd0, 1'b1, 32'h80000001, 1'b1}, // R5
    '{4'd6,  32'h80000000, 2'd1, 5'd0,  8'd0,   1'b0, 1'b0, 8'h00, 4'd0, 1'b0, 32'h00000000, 1'b1}, // R6
    '{4'd6,  32'h80000001, 2'd2, 5'd0,  8'd0,   1'b0, 1'b0, 8'h00, 4'd0, 1'b0, 32'hFFFFFFFF, 1'b1}, // R6
    '{4'd6,  32'h0000ABCD, 2'd0, 5'd0,  8'd0,   1'b0, 1'b0, 8'h00, 4'd0, 1'b1, 32'h0000ABCD, 1'b1}, // R6
    '{4'd7,  32'h12345678, 2'd1, 5'd7,  8'd0,   1'b1, 1'b0, 8'h00, 4'd0, 1'b1, 32'h12345678, 1'b1}, // R7
    '{4'd8,  32'h00000001, 2'd0, 5'd0,  8'd32,  1'b1, 1'b0, 8'h00, 4'd0, 1'b0, 32'h00000000, 1'b1}, // R8
    '{4'd8,  32'h80000000, 2'd1, 5'd0,  8'd32,  1'b1, 1'b0, 8'h00, 4'd0, 1'b0, 32'h00000000, 1'b1}, // R8
    '{4'd8,  32'hFFFFFFFF, 2'd0, 5'd0,  8'd40,  1'b1, 1'b0, 8'h00, 4'd0, 1'b1, 32'h00000000, 1'b0}, // R8
    '{4'd9,  32'h80000000, 2'd2, 5'd0,  8'd200, 1'b1, 1'b0, 8'h00, 4'd0, 1'b0, 32'hFFFFFFFF, 1'b1}, // R9
    '{4'd9,  32'h7FFFFFFF, 2'd2, 5'd0,  8'd33,  1'b1, 1'b0, 8'h00, 4'd0, 1'b1, 32'h00000000, 1'b0}, // R9
    '{4'd10, 32'h80000001, 2'd3, 5'd0,  8'd64,  1'b1, 1'b0, 8'h00, 4'd0, 1'b0, 32'h80000001, 1'b1}, // R10
    '{4'd11, 32'h12345678, 2'd0, 5'd9,  8'd3,   1'b1, 1'b1, 8'hFF, 4'd4, 1'b0, 32'hFF000000, 1'b1}, // R11
    '{4'd11, 32'h12345678, 2'd2, 5'd1,  8'd0,   1'b0, 1'b1, 8'h3F, 4'd0, 1'b1, 32'h0000003F, 1'b1}, // R11
    '{4'd11, 32'hFFFFFFFF, 2'd3, 5'd0,  8'd0,   1'b0, 1'b1, 8'h01, 4'd1, 1'b1, 32'h40000000, 1'b0}, // R11
    '{4'd4,  32'h00000001, 2'd3, 5'd0,  8'd1,   1'b1, 1'b0, 8'h00, 4'd0, 1'b0, 32'h80000000, 1'b1}, // R4
    '{4'd2,  32'hFFFFFFFF, 2'd1, 5'd31, 8'd0,   1'b0, 1'b0, 8'h00, 4'd0, 1'b0, 32'h00000001, 1'b1}  // R2
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand = '0;
  logic [1:0]  shiftType = '0;
  logic [4:0]  immAmount = '0;
  logic [7:0]  regAmount = '0;
  logic        amountFromReg = 1'b0;
  logic        carryIn = 1'b0;
  logic        immMode = 1'b0;
  logic [7:0]  immConst = '0;
  logic [3:0]  immRotate = '0;
  logic [31:0] result;
  logic        carryOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  barrel_shift u_dut (
    .operand       (operand),
    .shiftType     (shiftType),
    .immAmount     (immAmount),
    .regAmount     (regAmount),
    .amountFromReg (amountFromReg),
    .carryIn       (carryIn),
    .immMode       (immMode),
    .immConst      (immConst),
    .immRotate     (immRotate),
    .result        (result),
    .carryOut      (carryOut)
  );

  // bit-at-a-time reference built from the requirements
  function automatic void refModel(input logic [31:0] op, input logic [1:0] kind,
                                   input logic [4:0] ia, input logic [7:0] ra,
                                   input logic fr, input logic cin, input logic lm,
                                   input logic [7:0] lit, input logic [3:0] rot,
                                   output logic [31:0] r, output logic c);
    int n;
    r = op;
    c = cin;
    if (lm) begin
      r = {24'b0, lit};
      for (int i = 0; i < 2 * int'(rot); i++) begin
        c = r[0];
        r = {r[0], r[31:1]};
      end
      return;
    end
    if (!fr && ia == 5'd0 && kind == 2'd3) begin
      c = r[0];
      r = {cin, r[31:1]};
      return;
    end
    if (fr)               n = int'(ra);
    else if (ia != 5'd0)  n = int'(ia);
    else if (kind == 2'd0) n = 0;
    else                   n = 32;
    for (int i = 0; i < n; i++) begin
      case (kind)
        2'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
        2'd1: begin c = r[0];  r = {1'b0, r[31:1]}; end
        2'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
  endfunction

  task automatic drive(input vec_t v);
    @(negedge clk);
    operand       = v.op;
    shiftType     = v.kind;
    immAmount     = v.immAmt;
    regAmount     = v.regAmt;
    amountFromReg = v.fromReg;
    carryIn       = v.cin;
    immMode       = v.litMode;
    immConst      = v.lit;
    immRotate     = v.rot;
    #1ns;
  endtask

  task automatic compare(input int req, input logic [31:0] expR, input logic expC);
    nChecks++;
    if (result !== expR || carryOut !== expC) begin
      nFails++;
      $display("FAIL R%0d: result=%h carry=%b expected result=%h carry=%b",
               req, result, carryOut, expR, expC);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stimulus
    vec_t v;
    logic [31:0] eR;
    logic        eC;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1ns;
    // reset state: all inputs zero, logical left by 0 is transparent (R6)
    compare(6, 32'h0, 1'b0);

    // table of worked vectors
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      compare(int'(VECS[i].req), VECS[i].expR, VECS[i].expC);
    end

    // register-amount sweep across every type, R1 R2 R3 R4 R7 R8 R9 R10
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 70; a += 3) begin
        for (int p = 0; p < 2; p++) begin
          v = '0;
          v.op      = p ? 32'hC3A55A3C : 32'h80000001;
          v.kind    = 2'(k);
          v.regAmt  = 8'(a);
          v.fromReg = 1'b1;
          v.cin     = p[0];
          refModel(v.op, v.kind, v.immAmt, v.regAmt, 1'b1, v.cin, 1'b0, 8'h0, 4'h0, eR, eC);
          drive(v);
          compare(k + 1, eR, eC);
        end
      end
    end

    // constant-amount sweep including amount 0 forms, R5 R6
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 32; a += 5) begin
        v = '0;
        v.op     = 32'h9E3779B9;
        v.kind   = 2'(k);
        v.immAmt = 5'(a);
        v.cin    = 1'b1;
        refModel(v.op, v.kind, v.immAmt, 8'h0, 1'b0, 1'b1, 1'b0, 8'h0, 4'h0, eR, eC);
        drive(v);
        compare(a == 0 ? 6 : k + 1, eR, eC);
      end
    end

    // rotated literal, every rotate value, shift inputs held busy: R11
    for (int r = 0; r < 16; r++) begin
      v = '0;
      v.op      = 32'hDEADBEEF;
      v.kind    = 2'd1;
      v.regAmt  = 8'd5;
      v.fromReg = 1'b1;
      v.litMode = 1'b1;
      v.lit     = 8'hA5;
      v.rot     = 4'(r);
      v.cin     = r[0];
      refModel(v.op, v.kind, 5'd0, 8'd5, 1'b1, v.cin, 1'b1, 8'hA5, 4'(r), eR, eC);
      drive(v);
      compare(11, eR, eC);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule